// File: doc/BRIEF.md
# Programmable 28-bit up-counting timer

This block is a single timer/counter behind a small word-addressed register port. Software loads an end value, can preload the running count, and starts the timer by writing a control word. The control word holds an enable bit, a mode bit and a clock divisor. While the timer runs, a prescaler turns every `divisor` input clocks into one tick. Each tick adds one to a 28-bit count.

A terminal event happens in two cases. The first is a tick that would bring the count up to the programmed end value. The second is a tick that would carry the count past its all-ones value. On a terminal event the count returns to zero and an interrupt pending flag is raised. In one-shot mode the hardware then clears its own enable bit, so the stop can be read back. In periodic mode the counter keeps going from zero. A single level interrupt output is asserted while the pending flag and the interrupt enable are both set. Software acknowledges the interrupt by writing one to the pending bit.

The register port is a plain single-cycle interface with no back-pressure. A write strobe commits on the clock edge. Read data is a combinational function of the address, so it is valid in the same cycle the address is applied.

Top module: `upcount_timer`

## Requirements
- R1: Registers are selected by `reg_addr[3:2]`: end value at byte offset 0x0, count at 0x4, control at 0x8, interrupt at 0xC. Control holds enable at bit 28, mode at bit 24 and the divisor at bits 15:0. Interrupt holds the enable at bit 20 and pending at bit 16. Every other bit reads 0, including bits 31:28 of the end and count registers.
- R2: After reset every register reads 0 and `irq` is low.
- R3: While enabled, the count rises by one every max(divisor,1) clocks. With divisor D, the first increment lands D clock edges after the edge that committed the enable.
- R4: While the enable bit is 0 the count holds its value, and writing 0 to the control register stops a running timer.
- R5: With a nonzero end value E, the tick that would make the count equal E sets it to 0 instead and raises pending, so the count cycles through 0..E-1. An end value of 0 turns off end matching.
- R6: A tick while the count is 0x0FFFFFFF sets the count to 0 and raises pending, whatever the end value.
- R7: With mode bit 24 at 0, a terminal event also clears the enable bit and counting stops at 0. With mode bit 24 at 1, counting continues from 0.
- R8: Writing 1 to interrupt bit 16 clears pending, and writing 0 there leaves it unchanged. A terminal event in the same cycle as a clearing write leaves pending set.
- R9: `irq` is high exactly when pending and the interrupt enable are both 1. Writing 0 to the interrupt register clears the enable and drops `irq`.
- R10: A write to the count register loads the low 28 bits of the data. It takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, committed on the rising edge |
| reg_addr | input | 4 | Byte address; bits 3:2 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: pending AND interrupt enable |

## Verification
The bench sweeps divisor 0 to 4 against end values 1 to 6 in both modes. After every clock it compares count, enable, pending and `irq` with values derived from floor(clocks/divisor).
- An off-by-one in the prescaler or in the end compare would shift the whole sequence and fail on the first terminal event.
- A one-shot that failed to clear its enable would keep counting after the stop.

Directed cases cover three more corners:
- The carry from 0x0FFFFFFF with end matching disabled, where a design that compared against a zero end value would wrap immediately.
- A clearing write that lands on the very edge of a terminal event, where a clear-wins flag would lose the interrupt.
- A count preload during a tick, where a design that let the tick win would be off by one.

// File: rtl/upt_pkg.sv
package upt_pkg;
  localparam int CNT_W  = 28;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam int CTRL_EN_BIT   = 28;
  localparam int CTRL_MODE_BIT = 24;
  localparam int IRQ_IEN_BIT   = 20;
  localparam int IRQ_PEND_BIT  = 16;

  typedef enum logic [1:0] {
    SEL_END  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_IRQ  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/upt_prescaler.sv
module upt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] phase_q;
  logic             last_phase;

  // divisor 0 and 1 both give one tick per clock
  always_comb begin
    last_phase = (div <= ONE) || (phase_q >= (div - ONE));
    tick       = run && last_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phase_q <= '0;
    else if (!run || restart || tick)  phase_q <= '0;
    else                               phase_q <= phase_q + ONE;
  end

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div > ONE) |-> (phase_q < div));

  // R4
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/upt_count_core.sv
module upt_count_core #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] end_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_inc;
  logic             hit_end;
  logic             hit_top;

  always_comb begin
    count_inc = count + ONE;
    hit_end   = (end_val != '0) && (count_inc == end_val);
    hit_top   = (count == TOP);
    wrap_evt  = tick && (hit_end || hit_top);
  end

  // software load has priority over the hardware update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load)     count <= load_val;
    else if (wrap_evt) count <= '0;
    else if (tick)     count <= count_inc;
  end

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load) |=> (count == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/upt_irq_ctl.sv
module upt_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr,
  input  logic wr_ien,
  input  logic wr_clr,
  output logic pend,
  output logic ien,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ien  <= 1'b0;
    end else begin
      if (set_evt)            pend <= 1'b1;
      else if (wr && wr_clr)  pend <= 1'b0;
      if (wr)                 ien  <= wr_ien;
    end
  end

  assign irq = pend & ien;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);

  // R9
  ien_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wr_ien) |=> !irq);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(wr && wr_clr)) |=> pend);
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import upt_pkg::*;
#(
  parameter int TCNT_W = CNT_W,
  parameter int TDIV_W = DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  reg_sel_e sel;
  logic     wr_end, wr_cnt, wr_ctrl, wr_irq;

  logic [TCNT_W-1:0] end_q;
  logic [TCNT_W-1:0] count;
  logic              run_q;
  logic              periodic_q;
  logic [TDIV_W-1:0] div_q;
  logic              tick;
  logic              wrap_evt;
  logic              pend, ien;
  logic              unused_bits;

  assign sel         = reg_sel_e'(reg_addr[3:2]);
  assign unused_bits = ^reg_addr[1:0];

  always_comb begin
    wr_end  = reg_wr && (sel == SEL_END);
    wr_cnt  = reg_wr && (sel == SEL_CNT);
    wr_ctrl = reg_wr && (sel == SEL_CTRL);
    wr_irq  = reg_wr && (sel == SEL_IRQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q      <= '0;
      run_q      <= 1'b0;
      periodic_q <= 1'b0;
      div_q      <= '0;
    end else begin
      if (wr_end) end_q <= reg_wdata[TCNT_W-1:0];
      if (wr_ctrl) begin
        run_q      <= reg_wdata[CTRL_EN_BIT];
        periodic_q <= reg_wdata[CTRL_MODE_BIT];
        div_q      <= reg_wdata[TDIV_W-1:0];
      end else if (wrap_evt && !periodic_q) begin
        run_q <= 1'b0;
      end
    end
  end

  upt_prescaler #(.DIV_W(TDIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_ctrl),
    .div     (div_q),
    .tick    (tick)
  );

  upt_count_core #(.CNT_W(TCNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .end_val  (end_q),
    .load     (wr_cnt),
    .load_val (reg_wdata[TCNT_W-1:0]),
    .count    (count),
    .wrap_evt (wrap_evt)
  );

  upt_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wrap_evt),
    .wr      (wr_irq),
    .wr_ien  (reg_wdata[IRQ_IEN_BIT]),
    .wr_clr  (reg_wdata[IRQ_PEND_BIT]),
    .pend    (pend),
    .ien     (ien),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_END:  reg_rdata[TCNT_W-1:0] = end_q;
      SEL_CNT:  reg_rdata[TCNT_W-1:0] = count;
      SEL_CTRL: begin
        reg_rdata[TDIV_W-1:0]    = div_q;
        reg_rdata[CTRL_MODE_BIT] = periodic_q;
        reg_rdata[CTRL_EN_BIT]   = run_q;
      end
      SEL_IRQ: begin
        reg_rdata[IRQ_PEND_BIT] = pend;
        reg_rdata[IRQ_IEN_BIT]  = ien;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !periodic_q && !wr_ctrl) |=> !run_q);

  // R7
  periodic_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && periodic_q && !wr_ctrl) |=> run_q);

  // R4
  no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);
endmodule

// File: tb/upcount_timer_test.sv
module upcount_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_END = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_IRQ = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  upcount_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; commits on the next posedge; returns at next negedge
  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    bus_rd(A_END, v);  chk("R2 end", v, 32'h0);
    bus_rd(A_CNT, v);  chk("R2 count", v, 32'h0);
    bus_rd(A_CTRL, v); chk("R2 ctrl", v, 32'h0);
    bus_rd(A_IRQ, v);  chk("R2 irq reg", v, 32'h0);
    chk("R2 irq pin", {31'b0, irq}, 32'h0);

    // R1 readback masking
    bus_wr(A_END, 32'hFFFF_FFFF);
    bus_rd(A_END, v);  chk("R1 end mask", v, 32'h0FFF_FFFF);
    bus_wr(A_CTRL, 32'hE7FF_ABCD);
    bus_rd(A_CTRL, v); chk("R1 ctrl mask", v, 32'h0100_ABCD);
    bus_wr(A_IRQ, 32'hFFEF_FFFF);
    bus_rd(A_IRQ, v);  chk("R1 irq mask", v, 32'h0);
    bus_wr(A_IRQ, 32'h0010_0000);
    bus_rd(A_IRQ, v);  chk("R1 irq ien", v, 32'h0010_0000);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_IRQ, 32'h0);

    // R10 load masking; R4 hold while disabled
    bus_wr(A_CNT, 32'hFFFF_FFFF);
    bus_rd(A_CNT, v);  chk("R10 count mask", v, 32'h0FFF_FFFF);
    bus_wr(A_CNT, 32'd77);
    wait_n(6);
    bus_rd(A_CNT, v);  chk("R4 hold disabled", v, 32'd77);

    // Sweep: R3 R5 R7 R9
    for (int mode = 0; mode < 2; mode++) begin
      for (int dv = 0; dv <= 4; dv++) begin
        for (int ev = 1; ev <= 6; ev++) begin
          int de;
          de = (dv < 1) ? 1 : dv;
          bus_wr(A_CTRL, 32'h0);
          bus_wr(A_IRQ, 32'h0011_0000);
          bus_wr(A_CNT, 32'h0);
          bus_wr(A_END, ev);
          bus_wr(A_CTRL, (32'h1 << 28) | (32'(mode) << 24) | 32'(dv));
          for (int k = 0; k <= de * (2 * ev + 1); k++) begin
            int t;
            logic [31:0] ec, ee, ep;
            t = k / de;
            if (mode == 1) begin
              ec = 32'(t % ev); ee = 1; ep = (t >= ev) ? 1 : 0;
            end else begin
              ec = (t < ev) ? 32'(t) : 0;
              ee = (t < ev) ? 1 : 0;
              ep = (t >= ev) ? 1 : 0;
            end
            bus_rd(A_CNT, v);  chk("R3 R5 count", v, ec);
            bus_rd(A_CTRL, v); chk("R7 enable", {31'b0, v[28]}, ee);
            bus_rd(A_IRQ, v);  chk("R5 pending", {31'b0, v[16]}, ep);
            chk("R9 irq pin", {31'b0, irq}, ep);
            @(negedge clk);
          end
        end
      end
    end

    // R6 natural wrap, end matching off (R5)
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_IRQ, 32'h0011_0000);
    bus_wr(A_END, 32'h0);
    bus_wr(A_CNT, 32'h0FFF_FFFD);
    bus_wr(A_CTRL, 32'h1100_0001);
    wait_n(2);
    bus_rd(A_CNT, v); chk("R6 at top", v, 32'h0FFF_FFFF);
    bus_rd(A_IRQ, v); chk("R6 no pend yet", {31'b0, v[16]}, 0);
    wait_n(1);
    bus_rd(A_CNT, v); chk("R6 wrapped", v, 32'h0);
    bus_rd(A_IRQ, v); chk("R6 pend", {31'b0, v[16]}, 1);
    wait_n(20);
    bus_rd(A_CNT, v); chk("R5 end zero no match", v, 32'd20);

    // R8 set wins over clear, then clear, then write-0 keeps
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_IRQ, 32'h0011_0000);
    bus_wr(A_CNT, 32'h0);
    bus_wr(A_END, 32'd4);
    bus_wr(A_CTRL, 32'h1100_0001);
    wait_n(3);
    bus_wr(A_IRQ, 32'h0011_0000);        // lands on the event edge
    bus_rd(A_CNT, v); chk("R8 wrap", v, 32'h0);
    bus_rd(A_IRQ, v); chk("R8 set wins", {31'b0, v[16]}, 1);
    bus_wr(A_IRQ, 32'h0011_0000);
    bus_rd(A_IRQ, v); chk("R8 w1c", {31'b0, v[16]}, 0);
    chk("R8 irq low", {31'b0, irq}, 0);
    wait_n(3);
    bus_rd(A_IRQ, v); chk("R8 re-set", {31'b0, v[16]}, 1);
    bus_wr(A_IRQ, 32'h0010_0000);
    bus_rd(A_IRQ, v); chk("R8 write 0 keeps", {31'b0, v[16]}, 1);
    chk("R9 irq high", {31'b0, irq}, 1);
    bus_wr(A_IRQ, 32'h0);
    bus_rd(A_IRQ, v); chk("R9 ien cleared", v, 32'h0001_0000);
    chk("R9 irq dropped", {31'b0, irq}, 0);

    // R4 stop via ctrl write 0
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CNT, c0);
    wait_n(5);
    bus_rd(A_CNT, v); chk("R4 stopped", v, c0);

    // R10 load wins over tick
    bus_wr(A_END, 32'h0);
    bus_wr(A_CNT, 32'h0);
    bus_wr(A_CTRL, 32'h1100_0001);
    wait_n(4);
    bus_rd(A_CNT, v); chk("R3 free count", v, 32'd4);
    bus_wr(A_CNT, 32'd100);
    bus_rd(A_CNT, v); chk("R10 load wins", v, 32'd100);
    wait_n(1);
    bus_rd(A_CNT, v); chk("R10 continues", v, 32'd101);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule